// File: doc/BRIEF.md
# Refresh Scheduler with Self-Refresh Exit Control

This block paces refresh operations for a memory built from dynamic cells. In normal operation it produces one auto-refresh per interval. It raises a request to the access controller and waits for a grant, which the controller gives once its current access cycle has finished. It then pulls the active-low refresh strobe down while it holds chip enable inactive. It counts a fixed pulse width and then a precharge width before it releases the memory bus again. Host traffic is stalled from the moment the request is raised until the precharge is over.

A sleep command puts the memory into self-refresh by holding the strobe low. After a hold time the block reports that self-refresh is in effect. A wake command raises the strobe and precharges. From that exit, the first refresh must start within a deadline, and the block raises a sticky flag if it does not. With burst mode selected, the wake is followed by one refresh per row, issued back to back, before the normal interval pacing starts again. A second sticky flag reports a grant that arrives too late, that is, a request left waiting for a whole interval.

Top module: `refresh_sched`

## Requirements
- R1: After reset, the strobe is high, chip-enable hold-off is low, no request is raised, the host is not stalled, and all flags and status outputs are low.
- R2: In normal operation `refresh_req` rises every INTERVAL clock cycles. The first rise comes INTERVAL cycles after reset is released, and the period does not depend on how long the grant takes.
- R3: From the clock edge that samples `refresh_grant` high while a request is raised, `refresh_strobe_n` is low for exactly PULSE_W cycles, with `ce_hold_off` high throughout.
- R4: After the pulse, the strobe is high and `ce_hold_off` stays high for exactly PRECH_W cycles. Both `ce_hold_off` and `host_stall` then drop, unless another refresh is due.
- R5: `host_stall` is high from the cycle the request rises until the precharge ends, and low while the block is idle.
- R6: `refresh_grant` has no effect while no request is raised. The strobe stays high and the interval timing is unchanged.
- R7: If a request stays ungranted for INTERVAL cycles, `grant_late_err` is set and remains set until reset.
- R8: `sleep_req` seen while idle pulls the strobe low with `ce_hold_off` high. `in_self_refresh` rises SR_HOLD cycles later, and no request is raised while asleep.
- R9: `wake_req` while in self-refresh raises the strobe on the next edge and clears `in_self_refresh`. After PRECH_W cycles of precharge, a refresh request is raised at once.
- R10: If the first refresh pulse after wake has not started DEADLINE cycles after the wake edge, `wake_miss_err` is set and remains set. A grant given in time leaves it low.
- R11: With `burst_en` high at wake, exactly ROWS refresh pulses are issued back to back, tracked by a counter of log2(ROWS) bits that wraps after the last one. `burst_active` is high over that run. The next paced request follows INTERVAL cycles after `burst_active` falls.
- R12: With `burst_en` low at wake, a single refresh follows the exit, and the next request comes INTERVAL cycles after the wake edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Host command to enter self-refresh (acted on when idle) |
| wake_req | input | 1 | Host command to leave self-refresh |
| burst_en | input | 1 | Select back-to-back refresh run after wake |
| refresh_grant | input | 1 | Access controller grants the bus for a refresh |
| refresh_req | output | 1 | Refresh request to the access controller |
| refresh_strobe_n | output | 1 | Active-low refresh strobe to the memory |
| ce_hold_off | output | 1 | Forces memory chip enable inactive |
| host_stall | output | 1 | Holds off new host accesses |
| in_self_refresh | output | 1 | Self-refresh hold time has elapsed |
| burst_active | output | 1 | Post-wake refresh run in progress |
| grant_late_err | output | 1 | Sticky: a grant missed a whole interval |
| wake_miss_err | output | 1 | Sticky: first refresh after wake was too late |

## Verification
A wrong interval count shows at the ports by the second request at the latest, as a `refresh_req` period that is off. A phase counter that is loaded wrongly shows within one refresh, as a wrong low width of the strobe or a wrong precharge width. A burst counter that wraps at the wrong point changes the number of strobe pulses seen before `burst_active` falls. A deadline counter that is off by one moves the rise of `wake_miss_err` by a cycle, so the bench counts cycles from each triggering edge to each observed change rather than only checking that it eventually occurs.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PULSE,
        ST_PRECH,
        ST_SLEEP
    } rs_state_e;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int unsigned PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic reload,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload) begin
            cnt_d = W'(PERIOD - 1);
        end else if (en) begin
            cnt_d = (cnt_q == '0) ? W'(PERIOD - 1) : cnt_q - 1'b1;
        end
    end

    assign tick = en && !reload && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(PERIOD - 1);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rs_deadline.sv
module rs_deadline #(
    parameter int unsigned LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    output logic miss
);
    localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_d, cnt_q;
    logic         armed_d, armed_q;

    always_comb begin
        cnt_d   = cnt_q;
        armed_d = armed_q;
        if (arm) begin
            armed_d = 1'b1;
            cnt_d   = W'(LIMIT - 1);
        end else if (disarm || miss) begin
            armed_d = 1'b0;
        end else if (armed_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign miss = armed_q && !disarm && !arm && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int unsigned ROWS     = 2048,
    parameter int unsigned INTERVAL = 1560,
    parameter int unsigned PULSE_W  = 9,
    parameter int unsigned PRECH_W  = 8,
    parameter int unsigned SR_HOLD  = 800,
    parameter int unsigned DEADLINE = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic burst_en,
    input  logic refresh_grant,
    output logic refresh_req,
    output logic refresh_strobe_n,
    output logic ce_hold_off,
    output logic host_stall,
    output logic in_self_refresh,
    output logic burst_active,
    output logic grant_late_err,
    output logic wake_miss_err
);
    localparam int unsigned BW   = (ROWS > 2) ? $clog2(ROWS) : 1;
    localparam int unsigned MAXP = (SR_HOLD > PULSE_W) ?
                                   ((SR_HOLD > PRECH_W) ? SR_HOLD : PRECH_W) :
                                   ((PULSE_W > PRECH_W) ? PULSE_W : PRECH_W);
    localparam int unsigned CW   = $clog2(MAXP + 1);

    typedef struct packed {
        rs_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] burst;
        logic          burst_on;
        logic          burst_last;
        logic          pend;
        logic          sr;
        logic          late;
        logic          miss;
    } rs_reg_t;

    rs_reg_t r_d, r_q;
    logic    tick, wake_go, burst_end, dl_disarm, dl_miss;

    rs_interval_timer #(.PERIOD(INTERVAL)) u_itv (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     ((r_q.st != ST_SLEEP) && !r_q.burst_on),
        .reload (wake_go || burst_end),
        .tick   (tick)
    );

    assign dl_disarm = (r_q.st == ST_REQ) && refresh_grant;

    rs_deadline #(.LIMIT(DEADLINE)) u_dl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wake_go),
        .disarm (dl_disarm),
        .miss   (dl_miss)
    );

    always_comb begin
        r_d       = r_q;
        wake_go   = 1'b0;
        burst_end = 1'b0;
        if (dl_miss) r_d.miss = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.pend || tick) begin
                    r_d.st   = ST_REQ;
                    r_d.pend = 1'b0;
                end else if (sleep_req) begin
                    r_d.st  = ST_SLEEP;
                    r_d.cnt = CW'(SR_HOLD - 1);
                end
            end
            ST_REQ: begin
                if (refresh_grant) begin
                    r_d.st  = ST_PULSE;
                    r_d.cnt = CW'(PULSE_W - 1);
                    if (tick) r_d.pend = 1'b1;
                    if (r_q.burst_on) begin
                        {r_d.burst_last, r_d.burst} = {1'b0, r_q.burst} + 1'b1;
                    end
                end else if (tick) begin
                    r_d.late = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tick) r_d.pend = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_PRECH;
                    r_d.cnt = CW'(PRECH_W - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRECH: begin
                if (tick) r_d.pend = 1'b1;
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.burst_on && r_q.burst_last) begin
                    r_d.burst_on   = 1'b0;
                    r_d.burst_last = 1'b0;
                    r_d.pend       = 1'b0;
                    r_d.st         = ST_IDLE;
                    burst_end      = 1'b1;
                end else if (r_q.burst_on || r_q.pend || tick) begin
                    r_d.st   = ST_REQ;
                    r_d.pend = 1'b0;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_SLEEP: begin
                if (!r_q.sr) begin
                    if (r_q.cnt == '0) r_d.sr = 1'b1;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end else if (wake_req) begin
                    r_d.sr         = 1'b0;
                    r_d.st         = ST_PRECH;
                    r_d.cnt        = CW'(PRECH_W - 1);
                    r_d.pend       = 1'b1;
                    r_d.burst_on   = burst_en;
                    r_d.burst      = '0;
                    r_d.burst_last = 1'b0;
                    wake_go        = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, burst: '0, burst_on: 1'b0,
                     burst_last: 1'b0, pend: 1'b0, sr: 1'b0,
                     late: 1'b0, miss: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign refresh_req      = (r_q.st == ST_REQ);
    assign refresh_strobe_n = !((r_q.st == ST_PULSE) || (r_q.st == ST_SLEEP));
    assign ce_hold_off      = (r_q.st == ST_PULSE) || (r_q.st == ST_PRECH) ||
                              (r_q.st == ST_SLEEP);
    assign host_stall       = (r_q.st != ST_IDLE);
    assign in_self_refresh  = r_q.sr;
    assign burst_active     = r_q.burst_on;
    assign grant_late_err   = r_q.late;
    assign wake_miss_err    = r_q.miss;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic refresh_req,
    input logic refresh_strobe_n,
    input logic ce_hold_off,
    input logic host_stall,
    input logic in_self_refresh,
    input logic burst_active,
    input logic grant_late_err,
    input logic wake_miss_err
);
    a_r3_strobe_holds_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_strobe_n |-> ce_hold_off);

    a_r5_holdoff_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ce_hold_off |-> host_stall);

    a_r2_req_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (refresh_strobe_n && !ce_hold_off && host_stall));

    a_r8_sleep_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_self_refresh |-> !refresh_strobe_n);

    a_r9_exit_raises_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_self_refresh) |-> refresh_strobe_n);

    a_r7_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        grant_late_err |=> grant_late_err);

    a_r10_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wake_miss_err |=> wake_miss_err);

    a_r11_burst_awake: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> !in_self_refresh);
endmodule

bind refresh_sched refresh_sched_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .refresh_req      (refresh_req),
    .refresh_strobe_n (refresh_strobe_n),
    .ce_hold_off      (ce_hold_off),
    .host_stall       (host_stall),
    .in_self_refresh  (in_self_refresh),
    .burst_active     (burst_active),
    .grant_late_err   (grant_late_err),
    .wake_miss_err    (wake_miss_err)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int ROWS = 8, INTERVAL = 40, PULSE_W = 3, PRECH_W = 2;
    localparam int SR_HOLD = 10, DEADLINE = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, burst_en = 1'b0, grant = 1'b0;
    logic req, strobe_n, hold, stall, sr, bact, late, miss;
    int   total = 0, bad = 0, cyc = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .PULSE_W(PULSE_W),
                    .PRECH_W(PRECH_W), .SR_HOLD(SR_HOLD), .DEADLINE(DEADLINE)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .burst_en(burst_en), .refresh_grant(grant), .refresh_req(req),
        .refresh_strobe_n(strobe_n), .ce_hold_off(hold), .host_stall(stall),
        .in_self_refresh(sr), .burst_active(bact), .grant_late_err(late),
        .wake_miss_err(miss));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // count negedges until req is high (at most lim)
    task automatic wait_req(output int n, input int lim);
        n = 0;
        while (!req && n < lim) begin @(negedge clk); n++; end
    endtask

    // grant after delay cycles, then measure pulse and precharge widths
    task automatic refresh_once(input int delay, input string tag);
        int w, p;
        repeat (delay) @(negedge clk);
        chk({tag, " R5 stall while waiting"}, stall, 1);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        w = 0;
        while (!strobe_n && w < 100) begin
            if (!hold) chk({tag, " R3 ce hold-off in pulse"}, hold, 1);
            w++; @(negedge clk);
        end
        chk({tag, " R3 pulse width"}, w, PULSE_W);
        p = 0;
        while (hold && p < 100) begin
            if (!strobe_n) chk({tag, " R4 strobe high in precharge"}, strobe_n, 1);
            p++; @(negedge clk);
        end
        chk({tag, " R4 precharge width"}, p, PRECH_W);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, t0, k, pulses;
        logic prev;
        repeat (3) @(negedge clk);
        chk("R1 strobe", strobe_n, 1);
        chk("R1 req", req, 0);
        chk("R1 hold", hold, 0);
        chk("R1 stall", stall, 0);
        chk("R1 flags", {sr, bact, late, miss}, 0);
        rst_n = 1'b1;
        // R6: stray grant while idle has no effect
        grant = 1'b1;
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); n++;
            if (!strobe_n || req) chk("R6 stray grant ignored", strobe_n, 1);
        end
        grant = 1'b0;
        chk("R6 strobe after stray grant", strobe_n, 1);
        chk("R5 idle no stall", stall, 0);
        wait_req(k, 1000);
        chk("R2 first request", n + k, INTERVAL);
        // sweep of grant latencies, R2 period checked each time
        for (int d = 0; d < 12; d += 3) begin
            t0 = cyc;
            refresh_once(d, "sweep");
            chk("R5 idle after refresh", stall, 0);
            wait_req(k, 1000);
            chk("R2 period", cyc - t0, INTERVAL);
        end
        // R7: let a request wait a whole interval
        t0 = cyc;
        while (!late && cyc - t0 < 200) @(negedge clk);
        chk("R7 late flag timing", cyc - t0, INTERVAL);
        refresh_once(0, "late");
        repeat (7) @(negedge clk);
        chk("R7 late flag sticky", late, 1);
        // R8: sleep
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R8 strobe low on sleep", strobe_n, 0);
        chk("R8 hold-off on sleep", hold, 1);
        n = 0;
        while (!sr && n < 100) begin @(negedge clk); n++; end
        chk("R8 self-refresh delay", n, SR_HOLD);
        n = 0;
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            @(negedge clk);
            if (req || strobe_n) n++;
        end
        chk("R8 no request asleep", n, 0);
        // R9/R12: wake without burst
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        t0 = cyc;
        chk("R9 strobe rises", strobe_n, 1);
        chk("R9 sr cleared", sr, 0);
        chk("R9 precharge hold-off", hold, 1);
        wait_req(k, 100);
        chk("R9 request after exit precharge", k, PRECH_W);
        refresh_once(0, "wake");
        chk("R10 no miss when prompt", miss, 0);
        chk("R12 single refresh only", bact, 0);
        wait_req(k, 1000);
        chk("R12 paced after wake", cyc - t0, INTERVAL);
        refresh_once(1, "post");
        // R11: burst after wake
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        while (!sr) @(negedge clk);
        burst_en = 1'b1;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        burst_en = 1'b0;
        grant = 1'b1;
        chk("R11 burst active", bact, 1);
        pulses = 0; prev = strobe_n; n = 0;
        while (bact && n < 2000) begin
            @(negedge clk); n++;
            if (prev && !strobe_n) pulses++;
            prev = strobe_n;
        end
        grant = 1'b0;
        t0 = cyc;
        chk("R11 burst pulse count", pulses, ROWS);
        chk("R10 no miss in burst", miss, 0);
        wait_req(k, 1000);
        chk("R11 pacing after burst", cyc - t0, INTERVAL);
        refresh_once(2, "after burst");
        // R10: deadline miss
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        while (!sr) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        t0 = cyc;
        while (!miss && cyc - t0 < 100) @(negedge clk);
        chk("R10 deadline miss timing", cyc - t0, DEADLINE);
        refresh_once(0, "miss");
        chk("R10 miss sticky", miss, 1);
        finish_run();
    end
endmodule